// File: doc/BRIEF.md
# Line-Counted Scrambler Status Watchdog

Once a video transmitter turns on scrambling, the attached display must confirm within a fixed deadline that it has locked onto the scrambled stream. This block enforces that deadline. It measures time in video lines, not in clock cycles, by counting rising edges of the horizontal sync. While the deadline runs, it asks a separate DDC agent at regular intervals to read the sink's scrambling status bit. The serial transfer itself is out of scope.

A restart loads the line budget from `timeout_lines_i`. If that input is zero, the block uses a default budget. The default is derived from the vertical total and frame rate parameters and a 200 ms deadline. If the derivation gives no usable value, the block falls back to 28571 lines.

A status read that returns 1 stops the watchdog quietly. Running out of lines while the status still reads 0 records a timeout. DDC aborts and the two kinds of NACK also leave flags. All flags are sticky, and any set flag drives the interrupt. Software clears a flag by writing 1 to the bit just above it.

Top module: `scrambler_watchdog`

## Requirements
- R1: With `timeout_lines_i` = 0, the budget is (DEADLINE_MS*1000) / (1000000 / (vertical total * FPS)), using integer division. The vertical total is active + front porch + sync + back porch lines. With the default parameters (2250 lines, 60 fps, 200 ms) the budget is 28571 lines. If the computation yields zero or does not fit, 28571 is used.
- R2: Only rising edges of `hsync_i` count as lines. A budget of N expires on the Nth rising edge after restart is released.
- R3: If no good status has been seen by expiry, the timeout flag at `stat_o[8]` is set and `irq_o` rises.
- R4: A status read with `rd_valid_i`=1 and `rd_status_i`=1 while running stops the watchdog. No timeout flag is set afterwards and polling stops. A good read that arrives in the same cycle as the expiring edge wins.
- R5: While running, `poll_req_o` pulses for one cycle after every POLL_LINES counted lines. No pulse is issued on the expiring line or after the watchdog stops.
- R6: While enabled, `ddc_abort_i` sets `stat_o[4]`, `ddc_nack0_i` sets `stat_o[12]` and `ddc_nack1_i` sets `stat_o[14]`. `irq_o` is the OR of all flags.
- R7: Flags are sticky. A cycle with `clr_wr_i`=1 and `clr_data_i` bit 5, 9, 13 or 15 set clears flag 4, 8, 12 or 14 respectively. A set in the same cycle as its clear wins. Writing the flag's own bit clears nothing.
- R8: While `restart_i` is high, both line counters hold their reload values. The deadline is measured from the release of `restart_i`, and a restart in mid-run starts the count over.
- R9: With `cfg_en_i` low, the watchdog is idle. It issues no polls, and status results, DDC errors and restarts are ignored. Re-enabling requires a restart to run again.
- R10: After expiry, the counter stays at its end state until the next restart. No polls are issued, and a cleared timeout flag stays cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Enables hardware access to the sink status |
| restart_i | input | 1 | Level; holds and reloads the line counters |
| timeout_lines_i | input | LINE_W | Line budget; 0 selects the default |
| hsync_i | input | 1 | Horizontal sync, synchronous to clk_i |
| rd_valid_i | input | 1 | A status read has completed |
| rd_status_i | input | 1 | Sink scrambling status from that read |
| ddc_abort_i | input | 1 | DDC transfer aborted |
| ddc_nack0_i | input | 1 | First-phase NACK |
| ddc_nack1_i | input | 1 | Second-phase NACK |
| clr_wr_i | input | 1 | Write strobe for the clear word |
| clr_data_i | input | 16 | Clear word; bit p+1 clears flag p |
| poll_req_o | output | 1 | One-cycle request for a status read |
| irq_o | output | 1 | Interrupt, OR of the sticky flags |
| stat_o | output | 16 | Flags at bits 4, 8, 12, 14; other bits 0 |

## Verification
Two functions can land in the same cycle. One is the expiring hsync edge. The other is a good status result, which must suppress the timeout. The bench provokes this by raising `hsync_i` for the last budgeted line in the same cycle that it presents `rd_valid_i` with `rd_status_i`=1. It then judges that `stat_o[8]` and `irq_o` stay low and that no later lines set the flag. A second collision, a DDC error together with the clear write for its flag, is judged by the flag staying set.

// File: rtl/scw_pkg.sv
package scw_pkg;
  localparam int unsigned FALLBACK_LINES = 28571;
  localparam int unsigned NCAUSE = 4;
  localparam int unsigned STAT_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PASS, ST_EXPIRED} wd_state_e;

  // flag index: 0 abort, 1 timeout, 2 nack0, 3 nack1
  function automatic int unsigned flag_pos(int unsigned idx);
    case (idx)
      0: flag_pos = 4;
      1: flag_pos = 8;
      2: flag_pos = 12;
      default: flag_pos = 14;
    endcase
  endfunction

  function automatic int unsigned deadline_lines(int unsigned vtot, int unsigned fps,
                                                 int unsigned ms);
    int unsigned line_us;
    if (vtot * fps == 0) return 0;
    line_us = 1000000 / (vtot * fps);
    if (line_us == 0) return 0;
    return (ms * 1000) / line_us;
  endfunction
endpackage

// File: rtl/scw_rise.sv
module scw_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/scw_line_timer.sv
module scw_line_timer #(
  parameter int unsigned LINE_W     = 16,
  parameter int unsigned POLL_LINES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LINE_W-1:0] load_val_i,
  input  logic              run_i,
  input  logic              tick_i,
  output logic              expire_o,
  output logic              poll_o
);
  localparam int unsigned PW = (POLL_LINES > 2) ? $clog2(POLL_LINES) : 1;
  localparam logic [PW-1:0] PMAX = PW'(POLL_LINES - 1);

  logic [LINE_W-1:0] cnt_q;
  logic [PW-1:0]     pcnt_q;
  logic              poll_q;

  assign expire_o = run_i && tick_i && (cnt_q == LINE_W'(1));
  assign poll_o   = poll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
      poll_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      pcnt_q <= '0;
      poll_q <= 1'b0;
    end else begin
      poll_q <= 1'b0;
      if (run_i && tick_i) begin
        if (cnt_q != '0) cnt_q <= cnt_q - LINE_W'(1);  // saturate at zero
        if (pcnt_q == PMAX) begin
          pcnt_q <= '0;
          poll_q <= ~expire_o;
        end else begin
          pcnt_q <= pcnt_q + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/scw_flags.sv
module scw_flags
  import scw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCAUSE-1:0] set_i,
  input  logic              clr_wr_i,
  input  logic [STAT_W-1:0] clr_data_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              any_o
);
  logic [NCAUSE-1:0] flag_q;

  for (genvar g = 0; g < NCAUSE; g++) begin : g_flag
    localparam int unsigned POS = flag_pos(g);
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                           flag_q[g] <= 1'b0;
      else if (set_i[g])                     flag_q[g] <= 1'b1;  // set beats clear
      else if (clr_wr_i && clr_data_i[POS+1]) flag_q[g] <= 1'b0;
  end

  always_comb begin
    stat_o = '0;
    for (int i = 0; i < NCAUSE; i++) stat_o[flag_pos(i)] = flag_q[i];
  end
  assign any_o = |flag_q;
endmodule

// File: rtl/scrambler_watchdog.sv
module scrambler_watchdog
  import scw_pkg::*;
#(
  parameter int unsigned LINE_W      = 16,
  parameter int unsigned POLL_LINES  = 8,
  parameter int unsigned V_ACTIVE    = 2160,
  parameter int unsigned V_FPORCH    = 8,
  parameter int unsigned V_SYNC      = 10,
  parameter int unsigned V_BPORCH    = 72,
  parameter int unsigned FPS         = 60,
  parameter int unsigned DEADLINE_MS = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              restart_i,
  input  logic [LINE_W-1:0] timeout_lines_i,
  input  logic              hsync_i,
  input  logic              rd_valid_i,
  input  logic              rd_status_i,
  input  logic              ddc_abort_i,
  input  logic              ddc_nack0_i,
  input  logic              ddc_nack1_i,
  input  logic              clr_wr_i,
  input  logic [15:0]       clr_data_i,
  output logic              poll_req_o,
  output logic              irq_o,
  output logic [15:0]       stat_o
);
  localparam int unsigned V_TOTAL = V_ACTIVE + V_FPORCH + V_SYNC + V_BPORCH;
  localparam int unsigned CALC    = deadline_lines(V_TOTAL, FPS, DEADLINE_MS);
  localparam int unsigned DEF_LINES =
    (CALC == 0 || CALC >= (1 << LINE_W)) ? FALLBACK_LINES : CALC;

  wd_state_e         state_q, state_d;
  logic              tick, load, run, expire, poll, good, timeout_set;
  logic [LINE_W-1:0] load_val;
  logic [NCAUSE-1:0] set_vec;

  assign load     = cfg_en_i & restart_i;
  assign run      = cfg_en_i & ~restart_i & (state_q == ST_RUN);
  assign load_val = (timeout_lines_i == '0) ? LINE_W'(DEF_LINES) : timeout_lines_i;
  assign good     = run & rd_valid_i & rd_status_i;
  assign timeout_set = expire & ~good;

  scw_rise i_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (hsync_i),
    .rise_o (tick)
  );

  scw_line_timer #(.LINE_W(LINE_W), .POLL_LINES(POLL_LINES)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .run_i      (run),
    .tick_i     (tick),
    .expire_o   (expire),
    .poll_o     (poll)
  );

  always_comb begin
    state_d = state_q;
    if (!cfg_en_i)              state_d = ST_IDLE;
    else if (restart_i)         state_d = ST_RUN;
    else if (state_q == ST_RUN) begin
      if (good)                 state_d = ST_PASS;
      else if (expire)          state_d = ST_EXPIRED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign set_vec = {ddc_nack1_i & cfg_en_i, ddc_nack0_i & cfg_en_i,
                    timeout_set, ddc_abort_i & cfg_en_i};

  scw_flags i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_wr_i   (clr_wr_i),
    .clr_data_i (clr_data_i),
    .stat_o     (stat_o),
    .any_o      (irq_o)
  );

  assign poll_req_o = poll & cfg_en_i;
endmodule

// File: rtl/scw_watchdog_chk.sv
module scw_watchdog_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_en_i,
  input logic        rd_valid_i,
  input logic        rd_status_i,
  input logic        ddc_abort_i,
  input logic        ddc_nack0_i,
  input logic        clr_wr_i,
  input logic [15:0] clr_data_i,
  input logic        poll_req_o,
  input logic [15:0] stat_o
);
  p_no_poll_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |-> !poll_req_o);

  p_poll_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_req_o |=> !poll_req_o);

  p_abort_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i && ddc_abort_i |=> stat_o[4]);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i && ddc_nack0_i |=> stat_o[12]);

  p_abort_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[4] && !(clr_wr_i && clr_data_i[5]) |=> stat_o[4]);

  p_abort_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i && clr_data_i[5] && !(cfg_en_i && ddc_abort_i) |=> !stat_o[4]);

  p_good_blocks_timeout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[8]) |-> !$past(cfg_en_i && rd_valid_i && rd_status_i));
endmodule

bind scrambler_watchdog scw_watchdog_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_en_i    (cfg_en_i),
  .rd_valid_i  (rd_valid_i),
  .rd_status_i (rd_status_i),
  .ddc_abort_i (ddc_abort_i),
  .ddc_nack0_i (ddc_nack0_i),
  .clr_wr_i    (clr_wr_i),
  .clr_data_i  (clr_data_i),
  .poll_req_o  (poll_req_o),
  .stat_o      (stat_o)
);

// File: tb/test_scrambler_watchdog.sv
`timescale 1ns/1ps
module test_scrambler_watchdog;
  localparam int LW = 16;
  localparam int PL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 0, restart = 0, hsync = 0, rd_valid = 0, rd_status = 0;
  logic abort = 0, nack0 = 0, nack1 = 0, clr_wr = 0;
  logic [LW-1:0] tmo = '0;
  logic [15:0] clr_data = '0;
  logic poll_req, irq;
  logic [15:0] stat;

  int n_chk = 0, n_bad = 0, polls = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scrambler_watchdog #(.LINE_W(LW), .POLL_LINES(PL)) i_scrambler_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .restart_i(restart),
    .timeout_lines_i(tmo), .hsync_i(hsync), .rd_valid_i(rd_valid),
    .rd_status_i(rd_status), .ddc_abort_i(abort), .ddc_nack0_i(nack0),
    .ddc_nack1_i(nack1), .clr_wr_i(clr_wr), .clr_data_i(clr_data),
    .poll_req_o(poll_req), .irq_o(irq), .stat_o(stat));

  always @(negedge clk) if (poll_req) polls++;

  // timeout, good-after-line (0 = none), lines run, expected flag, expected polls
  localparam logic [15:0] VEC [5][5] = '{
    '{16'd3,  16'd0, 16'd5,  16'd1, 16'd0},
    '{16'd10, 16'd0, 16'd12, 16'd1, 16'd2},
    '{16'd8,  16'd0, 16'd10, 16'd1, 16'd1},
    '{16'd12, 16'd5, 16'd14, 16'd0, 16'd1},
    '{16'd1,  16'd0, 16'd3,  16'd1, 16'd0}
  };

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic line();
    @(negedge clk) hsync = 1;
    @(negedge clk) hsync = 0;
  endtask

  task automatic lines(int n);
    for (int i = 0; i < n; i++) line();
  endtask

  task automatic good_read();
    @(negedge clk) begin rd_valid = 1; rd_status = 1; end
    @(negedge clk) begin rd_valid = 0; rd_status = 0; end
  endtask

  task automatic clear(logic [15:0] m);
    @(negedge clk) begin clr_wr = 1; clr_data = m; end
    @(negedge clk) begin clr_wr = 0; clr_data = '0; end
  endtask

  task automatic start(logic [LW-1:0] t);
    @(negedge clk) begin tmo = t; restart = 1; end
    @(negedge clk);
    @(negedge clk) restart = 0;
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset stat", stat, 0);
    chk("reset irq", irq, 0);
    chk("reset poll", poll_req, 0);
    cfg_en = 1;

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < 5; v++) begin
      clear(16'hFFFF);
      start(VEC[v][0]);
      p0 = polls;
      for (int l = 1; l <= int'(VEC[v][2]); l++) begin
        line();
        if (l == int'(VEC[v][1])) good_read();
      end
      repeat (2) @(negedge clk);
      chk($sformatf("R3 timeout flag vec%0d", v), stat[8], VEC[v][3][0]);
      chk($sformatf("R3 irq vec%0d", v), irq, VEC[v][3][0]);
      chk($sformatf("R5 polls vec%0d", v), polls - p0, VEC[v][4]);
    end

    // R2: held-high hsync counts once
    clear(16'hFFFF);
    start(16'd2);
    @(negedge clk) hsync = 1;
    repeat (10) @(negedge clk);
    hsync = 0;
    @(negedge clk);
    chk("R2 held hsync one line", stat[8], 0);
    line();
    @(negedge clk);
    chk("R2 second edge expires", stat[8], 1);

    // R4: good read in the expiring cycle wins
    clear(16'hFFFF);
    start(16'd4);
    lines(3);
    @(negedge clk) begin hsync = 1; rd_valid = 1; rd_status = 1; end
    @(negedge clk) begin hsync = 0; rd_valid = 0; rd_status = 0; end
    lines(3);
    chk("R4 same-cycle good read", stat[8], 0);
    chk("R4 same-cycle irq", irq, 0);

    // R8: restart mid-run
    start(16'd4);
    lines(3);
    start(16'd4);
    lines(3);
    chk("R8 restart extends deadline", stat[8], 0);
    line();
    @(negedge clk);
    chk("R8 expiry after restart", stat[8], 1);

    // R10: saturation after expiry
    clear(16'h0200);
    p0 = polls;
    lines(9);
    chk("R10 flag stays cleared", stat[8], 0);
    chk("R10 no polls after expiry", polls - p0, 0);

    // R6 / R7 error flags
    @(negedge clk) abort = 1;
    @(negedge clk) abort = 0;
    chk("R6 abort bit4", stat, 16'h0010);
    chk("R6 irq", irq, 1);
    @(negedge clk) nack0 = 1;
    @(negedge clk) begin nack0 = 0; nack1 = 1; end
    @(negedge clk) nack1 = 0;
    chk("R6 nack bits", stat, 16'h5010);
    clear(16'h5010);
    chk("R7 own-bit write no clear", stat, 16'h5010);
    clear(16'h2000);
    chk("R7 clear nack0", stat, 16'h4010);
    clear(16'h8020);
    chk("R7 clear rest", stat, 16'h0000);
    chk("R7 irq low", irq, 0);
    @(negedge clk) begin abort = 1; clr_wr = 1; clr_data = 16'h0020; end
    @(negedge clk) begin abort = 0; clr_wr = 0; clr_data = '0; end
    chk("R7 set wins over clear", stat[4], 1);
    clear(16'hFFFF);

    // R9: disabled
    start(16'd3);
    @(negedge clk) cfg_en = 0;
    p0 = polls;
    @(negedge clk) begin abort = 1; nack1 = 1; end
    @(negedge clk) begin abort = 0; nack1 = 0; end
    lines(10);
    @(negedge clk) cfg_en = 1;
    lines(5);
    chk("R9 errors ignored", stat, 0);
    chk("R9 no polls", polls - p0, 0);
    @(negedge clk) cfg_en = 0;
    start(16'd2);
    @(negedge clk) cfg_en = 1;
    lines(4);
    chk("R9 restart ignored when off", stat[8], 0);

    // R1: default budget 28571 lines
    start(16'd0);
    lines(28570);
    @(negedge clk);
    chk("R1 before default expiry", stat[8], 0);
    line();
    @(negedge clk);
    chk("R1 default expiry", stat[8], 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule